// File: doc/BRIEF.md
# Folded-Scale Channel Normalizer with Rectifier

This block sits behind a ternary convolution core, whose outputs are plain integer sums of added and subtracted activations with no weight magnitude applied. For every channel it applies the inference form of batch normalization and then a rectifier, using one multiply and one add. The weight magnitude of the ternary filter has already been multiplied into the normalization gain offline, so no separate rescaling multiply is needed after the convolution.

Gain and bias are signed fixed-point words with `FRAC` fractional bits, supplied per channel on input vectors. They may be tied to constants or changed between samples, and they are captured together with the sample they apply to. The result is rounded half up to an integer, clamped to the signed output range, and then negatives are replaced with zero. A valid-qualified vector of channel sums goes in. A valid-qualified vector of non-negative results comes out two clock cycles later.

Top module: `chan_bn_relu`

## Requirements
- R1: For each channel k, the output equals relu(sat(round((gain_k*x_k + bias_k) / 2^FRAC))), where x_k, gain_k and bias_k are all taken from the cycle in which in_valid was sampled high.
- R2: Rounding adds 2^(FRAC-1) and then shifts right arithmetically by FRAC, so an exact half moves toward plus infinity. With FRAC=8, a value of 2.5 gives 3, a value of 3.5 gives 4, and 2.48 gives 2.
- R3: A rounded value above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1, which is 127 for OUT_W=8.
- R4: A rounded value below zero is output as zero, so the top bit of every output lane is always 0.
- R5: out_valid rises exactly two clock edges after the edge that samples in_valid high, and it stays low otherwise. Back-to-back inputs give back-to-back outputs.
- R6: While rst is high, out_valid and out_data are zero. They stay zero until the first valid result arrives.
- R7: While in_valid is low, changes on in_data, gain and bias have no effect, and out_data keeps its last result.
- R8: Channel k occupies bits [k*W +: W] of each vector port, where W is that port's lane width. The channels are computed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_data, gain and bias |
| in_data | input | NCH*IN_W | Signed convolution sums, one lane per channel |
| gain | input | NCH*COEF_W | Signed fixed-point folded gains |
| bias | input | NCH*COEF_W | Signed fixed-point biases |
| out_valid | output | 1 | Qualifies out_data |
| out_data | output | NCH*OUT_W | Non-negative results, one lane per channel |

## Verification
Unit gain with zero bias checks that values pass through unchanged and that each lane lands in the right bit positions. Half gains and a half-negative bias put results exactly on .5 and just below it, which separates half-up rounding from truncation and from round-to-even. Large gains, large biases and inputs at the exact edge of the range show whether the clamp is present and placed correctly. Negative inputs, gains and biases show the rectifier. A long random stream with gaps in valid and full-range coefficients catches product-width errors and latency errors, and checks that outputs hold while valid is low.

// File: rtl/car_pkg.sv
package car_pkg;
    localparam int CAR_NCH    = 4;
    localparam int CAR_IN_W   = 16;
    localparam int CAR_COEF_W = 16;
    localparam int CAR_FRAC   = 8;
    localparam int CAR_OUT_W  = 8;

    typedef struct packed {
        logic stage1;
        logic stage2;
    } car_valid_t;
endpackage

// File: rtl/car_valid_pipe.sv
module car_valid_pipe
    import car_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid_i,
    output logic mid_o,
    output logic valid_o
);
    car_valid_t vp_d, vp_q;

    always_comb begin
        vp_d        = vp_q;
        vp_d.stage1 = valid_i;
        vp_d.stage2 = vp_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (rst) vp_q <= '0;
        else     vp_q <= vp_d;
    end

    assign mid_o   = vp_q.stage1;
    assign valid_o = vp_q.stage2;

    // A result is only valid if a sample was accepted two edges earlier
    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(valid_i, 2));
    assert_accept_emerges_R5: assert property (@(posedge clk) disable iff (rst)
        mid_o |=> valid_o);
    assert_reset_quiet_R6: assert property (@(posedge clk)
        rst |=> !valid_o);
endmodule

// File: rtl/car_mul_lane.sv
module car_mul_lane #(
    parameter int IN_W   = 16,
    parameter int COEF_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en_i,
    input  logic signed [IN_W-1:0]    x_i,
    input  logic signed [COEF_W-1:0]  gain_i,
    input  logic signed [COEF_W-1:0]  bias_i,
    output logic signed [IN_W+COEF_W-1:0] prod_o,
    output logic signed [COEF_W-1:0]  bias_o
);
    localparam int PROD_W = IN_W + COEF_W;

    typedef struct packed {
        logic signed [PROD_W-1:0] prod;
        logic signed [COEF_W-1:0] bias;
    } mul_st_t;

    mul_st_t mul_d, mul_q;

    always_comb begin
        mul_d = mul_q;
        if (en_i) begin
            mul_d.prod = $signed(PROD_W'(x_i)) * $signed(PROD_W'(gain_i));
            mul_d.bias = bias_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mul_q <= '0;
        else     mul_q <= mul_d;
    end

    assign prod_o = mul_q.prod;
    assign bias_o = mul_q.bias;

    // Product and captured bias ignore the inputs while no sample is accepted
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(prod_o) && $stable(bias_o)));
endmodule

// File: rtl/car_out_lane.sv
module car_out_lane #(
    parameter int PROD_W = 32,
    parameter int COEF_W = 16,
    parameter int FRAC   = 8,
    parameter int OUT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_i,
    input  logic signed [PROD_W-1:0] prod_i,
    input  logic signed [COEF_W-1:0] bias_i,
    output logic [OUT_W-1:0]         y_o
);
    localparam int ACC_W = PROD_W + 2;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);

    typedef struct packed {
        logic [OUT_W-1:0] y;
    } out_st_t;

    out_st_t out_d, out_q;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] shifted;
    logic                    over;
    logic                    under;

    always_comb begin
        out_d   = out_q;
        acc     = $signed(ACC_W'(prod_i)) + $signed(ACC_W'(bias_i)) + HALF;
        shifted = acc >>> FRAC;
        over    = shifted > MAXV;
        under   = shifted[ACC_W-1];
        if (en_i) begin
            if (over)       out_d.y = MAXV[OUT_W-1:0];
            else if (under) out_d.y = '0;
            else            out_d.y = shifted[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign y_o = out_q.y;

    assert_sat_cap_R3: assert property (@(posedge clk) disable iff (rst)
        (en_i && over) |=> (y_o == MAXV[OUT_W-1:0]));
    assert_relu_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (en_i && under) |=> (y_o == '0));
    assert_lane_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
        !y_o[OUT_W-1]);
    assert_lane_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(y_o));
endmodule

// File: rtl/chan_bn_relu.sv
module chan_bn_relu
    import car_pkg::*;
#(
    parameter int NCH    = CAR_NCH,
    parameter int IN_W   = CAR_IN_W,
    parameter int COEF_W = CAR_COEF_W,
    parameter int FRAC   = CAR_FRAC,
    parameter int OUT_W  = CAR_OUT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [NCH*IN_W-1:0]     in_data,
    input  logic [NCH*COEF_W-1:0]   gain,
    input  logic [NCH*COEF_W-1:0]   bias,
    output logic                    out_valid,
    output logic [NCH*OUT_W-1:0]    out_data
);
    localparam int PROD_W = IN_W + COEF_W;

    logic mid_valid;

    car_valid_pipe u_valid (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .mid_o   (mid_valid),
        .valid_o (out_valid)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        logic signed [PROD_W-1:0] prod_q;
        logic signed [COEF_W-1:0] bias_q;

        car_mul_lane #(
            .IN_W   (IN_W),
            .COEF_W (COEF_W)
        ) u_mul (
            .clk    (clk),
            .rst    (rst),
            .en_i   (in_valid),
            .x_i    ($signed(in_data[k*IN_W +: IN_W])),
            .gain_i ($signed(gain[k*COEF_W +: COEF_W])),
            .bias_i ($signed(bias[k*COEF_W +: COEF_W])),
            .prod_o (prod_q),
            .bias_o (bias_q)
        );

        car_out_lane #(
            .PROD_W (PROD_W),
            .COEF_W (COEF_W),
            .FRAC   (FRAC),
            .OUT_W  (OUT_W)
        ) u_out (
            .clk    (clk),
            .rst    (rst),
            .en_i   (mid_valid),
            .prod_i (prod_q),
            .bias_i (bias_q),
            .y_o    (out_data[k*OUT_W +: OUT_W])
        );
    end

    // Before the first result, the data bus stays at its reset value
    assert_data_quiet_R6: assert property (@(posedge clk)
        rst |=> (out_data == '0));
endmodule

// File: tb/chan_bn_relu_bench.sv
`timescale 1ns/1ps
module chan_bn_relu_bench;
    localparam int NCH = 4, IN_W = 16, COEF_W = 16, FRAC = 8, OUT_W = 8;
    localparam longint HALF = 64'sd1 <<< (FRAC - 1);
    localparam longint MAXV = (64'sd1 <<< (OUT_W - 1)) - 1;
    localparam int NRAND = 200;

    logic clk = 0, rst = 1, in_valid = 0;
    logic [NCH*IN_W-1:0]   in_data = '0;
    logic [NCH*COEF_W-1:0] gain = '0, bias = '0;
    logic out_valid;
    logic [NCH*OUT_W-1:0]  out_data;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chan_bn_relu u_chan_bn_relu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .gain(gain), .bias(bias), .out_valid(out_valid), .out_data(out_data));

    function automatic logic [NCH*OUT_W-1:0] model(
        input logic [NCH*IN_W-1:0] xv, input logic [NCH*COEF_W-1:0] gv,
        input logic [NCH*COEF_W-1:0] bv);
        logic [NCH*OUT_W-1:0] r = '0;
        for (int k = 0; k < NCH; k++) begin
            longint x = longint'($signed(xv[k*IN_W +: IN_W]));
            longint g = longint'($signed(gv[k*COEF_W +: COEF_W]));
            longint b = longint'($signed(bv[k*COEF_W +: COEF_W]));
            longint s = (x * g + b + HALF) >>> FRAC;
            if (s > MAXV) s = MAXV;
            if (s < 0) s = 0;
            r[k*OUT_W +: OUT_W] = s[OUT_W-1:0];
        end
        return r;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [NCH*IN_W-1:0] pack16(input int a, input int b, input int c, input int d);
        return {16'(d), 16'(c), 16'(b), 16'(a)};
    endfunction

    // Single isolated sample: output must appear on the second edge and not before
    task automatic run_vec(input string req, input logic [NCH*IN_W-1:0] xv,
                           input logic [NCH*COEF_W-1:0] gv, input logic [NCH*COEF_W-1:0] bv);
        logic [NCH*OUT_W-1:0] exp = model(xv, gv, bv);
        @(negedge clk);
        in_data = xv; gain = gv; bias = bv; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check({req, " R5 early"}, out_valid, 0);
        @(negedge clk);
        check({req, " R5 valid"}, out_valid, 1);
        for (int k = 0; k < NCH; k++)
            check({req, " lane R8"}, out_data[k*OUT_W +: OUT_W], exp[k*OUT_W +: OUT_W]);
        @(negedge clk);
        check({req, " R5 single"}, out_valid, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R6 valid", out_valid, 0);
        check("R6 data", out_data, 0);
        rst = 0;
        @(negedge clk);
        check("R6 after", out_data, 0);
    endtask

    task automatic test_identity();
        run_vec("R1 unity", pack16(3, 50, 0, 127), pack16(256, 256, 256, 256), '0);
        run_vec("R1 mixed", pack16(10, 4, 100, 7), pack16(512, 64, 384, 1024), pack16(256, 0, -512, 0));
    endtask

    task automatic test_rounding();
        // 2.5->3, 3.5->4, 2.48->2, 3.0-0.5 bias ->3
        run_vec("R2 half", pack16(5, 7, 5, 3), pack16(128, 128, 127, 256), pack16(0, 0, 0, -128));
        run_vec("R2 below", pack16(1, 1, 3, 0), pack16(127, 128, 85, 0), pack16(0, 0, 0, 127));
    endtask

    task automatic test_saturation();
        run_vec("R3 clamp", pack16(200, 32767, 0, 128), pack16(256, 32767, 0, 256), pack16(0, 0, 32767, 0));
        run_vec("R3 edge", pack16(127, -32768, 126, 0), pack16(256, -32768, 256, 0), pack16(0, 0, 255, 32639));
    endtask

    task automatic test_relu();
        run_vec("R4 neg", pack16(-5, 5, 0, -32768), pack16(256, -256, 0, 32767), pack16(0, 0, -100, 0));
    endtask

    task automatic test_hold();
        logic [NCH*OUT_W-1:0] last;
        run_vec("R7 seed", pack16(9, 20, 30, 40), pack16(256, 256, 256, 256), '0);
        last = out_data;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_data = pack16(100 + i, -7, 77, 1); gain = '1; bias = pack16(5000, 5000, 5000, 5000);
            check("R7 idle valid", out_valid, 0);
            check("R7 idle data", out_data, last);
        end
        @(negedge clk);
        check("R7 held", out_data, last);
    endtask

    task automatic test_random();
        logic [NCH*OUT_W-1:0] exp_mem [NRAND];
        bit v_mem [NRAND];
        logic [NCH*OUT_W-1:0] last = out_data;
        for (int i = 0; i < NRAND + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R5 stream", out_valid, v_mem[i-2]);
                if (v_mem[i-2]) last = exp_mem[i-2];
                check("R1 stream", out_data, last);
            end
            if (i < NRAND) begin
                logic [NCH*IN_W-1:0] xv;
                logic [NCH*COEF_W-1:0] gv, bv;
                for (int k = 0; k < NCH; k++) begin
                    xv[k*IN_W +: IN_W]     = (i % 3 == 0) ? IN_W'($urandom) : IN_W'($signed(8'($urandom)));
                    gv[k*COEF_W +: COEF_W] = (i % 4 == 0) ? COEF_W'($urandom) : COEF_W'($signed(10'($urandom)));
                    bv[k*COEF_W +: COEF_W] = COEF_W'($signed(14'($urandom)));
                end
                v_mem[i] = (i % 5 != 4);
                exp_mem[i] = model(xv, gv, bv);
                in_data = xv; gain = gv; bias = bv; in_valid = v_mem[i];
            end else begin
                in_valid = 0;
            end
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_identity();
        test_rounding();
        test_saturation();
        test_relu();
        test_hold();
        test_random();
        done = 1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule